// File: doc/BRIEF.md
# Compare Scan Sequencer

This block walks a run of memory elements and compares each one against a latched accumulator value. In byte mode the low eight bits of the accumulator are compared with a byte read. In word mode the full sixteen bits are compared with a word read. A pointer moves through memory and a sixteen-bit element count falls by one per element. The subtraction that forms the comparison sets condition flags, and its difference is thrown away.

A single form examines exactly one element. A repeat form keeps scanning until the count runs out or an equal element turns up. The pointer can move up or down. A memory-abort indication that comes with a read suppresses that element's comparison but still lets the pointer and count move on.

The surrounding core starts the block with the opcode's low three bits, the mode bits, the accumulator, the selected pointer's value, the count and the current flags. When the sequence ends, the core collects the updated pointer, count, flags, the reason for stopping and the nominal cycle cost.

Top module: `cmp_scan_engine`

## Requirements
- R1: After reset, busy, done, mem_req, end_found and end_empty are 0, and ptr_out, cnt_out, flags_out, ptr_sel and cycles are all 0. mem_req is never high while busy is low.
- R2: ptr_sel reports opcode_lo as it was sampled with the accepted start.
- R3: With word_mode=0 the block compares acc_in[7:0] with mem_rdata[7:0], ignores mem_rdata[15:8] and moves the pointer by 1. With word_mode=1 it compares acc_in[15:0] with mem_rdata[15:0] and moves the pointer by 2. mem_word shows the mode. mem_addr holds steady while a request waits for mem_ack.
- R4: With step_down=0 the pointer rises after each element; with step_down=1 it falls by the same step.
- R5: Flag vector bits are C=0, N=1, V=2, H=3, Z=4, S=5. Each comparison sets these flags for accumulator minus memory element, with the result at the active width. S is the result's top bit. Z is set when the result is zero. H is set on a borrow out of bit 3. N is set to 1. C is set on a borrow out of the top bit.
- R6: After each element the count falls by 1, and V is then set exactly when the new count is nonzero.
- R7: With repeat_mode=0 exactly one element is examined, and cycles reports 8.
- R8: With repeat_mode=1 the scan goes on after an element only while V=1 and Z=0.
- R9: With repeat_mode=1, cycles reports 10 plus 14 for each element examined.
- R10: When mem_abort is high together with mem_ack, that element's comparison is skipped. S, Z, H, N and C keep their earlier values, while the pointer, count and V still advance.
- R11: done is a one-cycle pulse at the end of a sequence. With it, end_found equals Z and end_empty shows that the count is zero.
- R12: A start pulse while busy is high is ignored and does not change the running sequence or its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| opcode_lo | input | 3 | Low three opcode bits: pointer register index |
| word_mode | input | 1 | 0 byte compare, 1 word compare |
| step_down | input | 1 | 0 pointer rises, 1 pointer falls |
| repeat_mode | input | 1 | 0 single element, 1 repeat until stop |
| acc_in | input | 16 | Accumulator value to compare |
| ptr_in | input | AW | Start value of the selected pointer |
| cnt_in | input | CW | Start value of the element count |
| flags_in | input | 6 | Flags before the sequence |
| mem_req | output | 1 | Read request |
| mem_addr | output | AW | Read address |
| mem_word | output | 1 | Read size: 1 word, 0 byte |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| mem_abort | input | 1 | Memory-abort condition for this read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end pulse |
| end_found | output | 1 | Stopped with an equal element (valid with done) |
| end_empty | output | 1 | Stopped with count zero (valid with done) |
| ptr_sel | output | 3 | Pointer register index to write back |
| ptr_out | output | AW | Current pointer |
| cnt_out | output | CW | Current count |
| flags_out | output | 6 | Current flags |
| cycles | output | CYW | Nominal cycle cost of the sequence |

## Verification
The assertions check the local rules on every cycle. Each element lowers the count by exactly one and moves the pointer by the mode's step. N follows every real comparison, and an aborted element leaves the other flags alone. A held request keeps its address, V at the end agrees with the count, and done lasts one cycle. A repeat sequence may stop only on V clear or Z set. Only the bench's scenarios can show the full results: whether a scan stops on the right element, the exact flag values for chosen data, the cycle totals, the abort landing on a would-be match, and a start pulse during a run being ignored.

// File: rtl/cmp_scan_pkg.sv
package cmp_scan_pkg;

  localparam int FL_C = 0;
  localparam int FL_N = 1;
  localparam int FL_V = 2;
  localparam int FL_H = 3;
  localparam int FL_Z = 4;
  localparam int FL_S = 5;
  localparam int FLW  = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } scan_state_e;

  // Flags of (a - m) at byte or word width; V slot left 0.
  function automatic logic [FLW-1:0] sub_flags(input logic [15:0] a,
                                               input logic [15:0] m,
                                               input logic        word);
    logic [FLW-1:0] f;
    logic [16:0]    dw;
    logic [8:0]     db;
    logic [4:0]     dn;
    dw = {1'b0, a} - {1'b0, m};
    db = {1'b0, a[7:0]} - {1'b0, m[7:0]};
    dn = {1'b0, a[3:0]} - {1'b0, m[3:0]};
    f        = '0;
    f[FL_N]  = 1'b1;
    f[FL_H]  = dn[4];
    if (word) begin
      f[FL_S] = dw[15];
      f[FL_Z] = (dw[15:0] == 16'h0000);
      f[FL_C] = dw[16];
    end else begin
      f[FL_S] = db[7];
      f[FL_Z] = (db[7:0] == 8'h00);
      f[FL_C] = db[8];
    end
    return f;
  endfunction

  function automatic logic [1:0] step_of(input logic word);
    return word ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/cmp_scan_ptr.sv
module cmp_scan_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          fire,
  input  logic          word,
  input  logic          down,
  output logic [AW-1:0] ptr_q
);
  import cmp_scan_pkg::*;

  logic [AW-1:0] step_ext;
  logic [AW-1:0] ptr_next;

  assign step_ext = AW'(step_of(word));
  assign ptr_next = down ? (ptr_q - step_ext) : (ptr_q + step_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_q <= '0;
    else if (load) ptr_q <= load_val;
    else if (fire) ptr_q <= ptr_next;
  end

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (($past(down) ? ($past(ptr_q) - ptr_q) : (ptr_q - $past(ptr_q)))
              == ($past(word) ? AW'(2) : AW'(1))));

endmodule

// File: rtl/cmp_scan_cnt.sv
module cmp_scan_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          fire,
  output logic [CW-1:0] cnt_q,
  output logic          nz_after
);
  logic [CW-1:0] cnt_after;

  assign cnt_after = cnt_q - 1'b1;
  assign nz_after  = (cnt_after != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (fire) cnt_q <= cnt_after;
  end

  p_cnt_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));

endmodule

// File: rtl/cmp_scan_flags.sv
module cmp_scan_flags
  import cmp_scan_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [FLW-1:0] load_val,
  input  logic           fire,
  input  logic           abort,
  input  logic           word,
  input  logic [15:0]    acc,
  input  logic [15:0]    rdata,
  input  logic           nz_after,
  output logic [FLW-1:0] flags_q,
  output logic           z_next
);
  logic [FLW-1:0] cmp_f;
  logic [FLW-1:0] nxt_f;

  always_comb begin
    cmp_f = sub_flags(acc, rdata, word);
    nxt_f = abort ? flags_q : cmp_f;
    nxt_f[FL_V] = nz_after;
  end

  assign z_next = nxt_f[FL_Z];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags_q <= '0;
    else if (load) flags_q <= load_val;
    else if (fire) flags_q <= nxt_f;
  end

  p_n_after_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !abort) |=> flags_q[FL_N]);

  p_abort_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && abort) |=> ((flags_q & 6'b111011) == ($past(flags_q) & 6'b111011)));

endmodule

// File: rtl/cmp_scan_ctrl.sv
module cmp_scan_ctrl
  import cmp_scan_pkg::*;
#(
  parameter int CYW         = 24,
  parameter int COST_SINGLE = 8,
  parameter int COST_SETUP  = 10,
  parameter int COST_ELEM   = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           repeat_mode,
  input  logic           mem_ack,
  input  logic           nz_after,
  input  logic           z_next,
  output logic           load,
  output logic           fire,
  output logic           busy,
  output logic           done,
  output logic           req,
  output logic           rep_q,
  output logic [CYW-1:0] cycles
);
  scan_state_e state_q, state_d;
  logic        keep_going;

  assign load       = (state_q == ST_IDLE) && start;
  assign req        = (state_q == ST_SCAN);
  assign fire       = req && mem_ack;
  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_FIN);
  assign keep_going = rep_q && nz_after && !z_next;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_SCAN;
      ST_SCAN: if (fire)  state_d = keep_going ? ST_SCAN : ST_FIN;
      ST_FIN:             state_d = ST_IDLE;
      default:            state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rep_q   <= 1'b0;
      cycles  <= '0;
    end else begin
      state_q <= state_d;
      if (load) begin
        rep_q  <= repeat_mode;
        cycles <= repeat_mode ? CYW'(COST_SETUP) : CYW'(COST_SINGLE);
      end else if (fire && rep_q) begin
        cycles <= cycles + CYW'(COST_ELEM);
      end
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_single_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rep_q) |-> (cycles == CYW'(COST_SINGLE)));

endmodule

// File: rtl/cmp_scan_engine.sv
module cmp_scan_engine
  import cmp_scan_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int CYW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     opcode_lo,
  input  logic           word_mode,
  input  logic           step_down,
  input  logic           repeat_mode,
  input  logic [15:0]    acc_in,
  input  logic [AW-1:0]  ptr_in,
  input  logic [CW-1:0]  cnt_in,
  input  logic [5:0]     flags_in,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_word,
  input  logic           mem_ack,
  input  logic [15:0]    mem_rdata,
  input  logic           mem_abort,
  output logic           busy,
  output logic           done,
  output logic           end_found,
  output logic           end_empty,
  output logic [2:0]     ptr_sel,
  output logic [AW-1:0]  ptr_out,
  output logic [CW-1:0]  cnt_out,
  output logic [5:0]     flags_out,
  output logic [CYW-1:0] cycles
);
  logic        load, fire, rep_q, nz_after, z_next;
  logic        word_q, down_q;
  logic [15:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= 1'b0;
      down_q  <= 1'b0;
      acc_q   <= '0;
      ptr_sel <= '0;
    end else if (load) begin
      word_q  <= word_mode;
      down_q  <= step_down;
      acc_q   <= acc_in;
      ptr_sel <= opcode_lo;
    end
  end

  cmp_scan_ctrl #(.CYW(CYW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .repeat_mode(repeat_mode),
    .mem_ack(mem_ack), .nz_after(nz_after), .z_next(z_next),
    .load(load), .fire(fire), .busy(busy), .done(done), .req(mem_req),
    .rep_q(rep_q), .cycles(cycles)
  );

  cmp_scan_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(ptr_in), .fire(fire),
    .word(word_q), .down(down_q), .ptr_q(ptr_out)
  );

  cmp_scan_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(cnt_in), .fire(fire),
    .cnt_q(cnt_out), .nz_after(nz_after)
  );

  cmp_scan_flags u_flags (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(flags_in), .fire(fire),
    .abort(mem_abort), .word(word_q), .acc(acc_q), .rdata(mem_rdata),
    .nz_after(nz_after), .flags_q(flags_out), .z_next(z_next)
  );

  assign mem_addr  = ptr_out;
  assign mem_word  = word_q;
  assign end_found = done && flags_out[FL_Z];
  assign end_empty = done && (cnt_out == '0);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_v_tracks_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flags_out[FL_V] == (cnt_out != '0)));

  p_stop_rule_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rep_q) |-> (!flags_out[FL_V] || flags_out[FL_Z]));

  p_busy_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(ptr_sel));

endmodule

// File: tb/test_cmp_scan_engine.sv
module test_cmp_scan_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, CW = 16, CYW = 24;
  localparam logic [5:0] FLAGS_PRE = 6'b101011;
  localparam int NV = 10;
  // {rep, down, word, sel[2:0], acc[15:0], ptr[7:0], cnt[15:0], abort_idx[7:0], n_expected[7:0]}
  localparam logic [61:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,3'd3,16'h0005,8'h00,16'd20,8'hFF,8'd6},
    {1'b1,1'b0,1'b0,3'd1,16'h0030,8'h00,16'd10,8'hFF,8'd10},
    {1'b1,1'b1,1'b0,3'd6,16'h0002,8'h08,16'd20,8'hFF,8'd7},
    {1'b1,1'b0,1'b1,3'd2,16'h1110,8'h0A,16'd10,8'hFF,8'd4},
    {1'b0,1'b0,1'b0,3'd7,16'h0000,8'h03,16'd1, 8'hFF,8'd1},
    {1'b0,1'b1,1'b1,3'd0,16'h0504,8'h04,16'd5, 8'hFF,8'd1},
    {1'b1,1'b0,1'b0,3'd5,16'h0007,8'h07,16'd1, 8'hFF,8'd1},
    {1'b1,1'b0,1'b0,3'd4,16'h0003,8'h00,16'd10,8'h03,8'd10},
    {1'b0,1'b0,1'b0,3'd2,16'h0009,8'h09,16'd3, 8'h00,8'd1},
    {1'b1,1'b1,1'b1,3'd3,16'h0203,8'h10,16'd4, 8'hFF,8'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, word_mode = 1'b0, step_down = 1'b0, repeat_mode = 1'b0;
  logic [2:0] opcode_lo = '0;
  logic [15:0] acc_in = '0;
  logic [AW-1:0] ptr_in = '0;
  logic [CW-1:0] cnt_in = '0;
  logic [5:0] flags_in = '0;
  logic mem_req, mem_word, busy, done, end_found, end_empty;
  logic [AW-1:0] mem_addr, ptr_out;
  logic mem_ack = 1'b0, mem_abort = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [2:0] ptr_sel;
  logic [CW-1:0] cnt_out;
  logic [5:0] flags_out;
  logic [CYW-1:0] cycles;

  logic [7:0] mem [64];
  int served = 0, abort_idx = 255;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_scan_engine #(.AW(AW), .CW(CW), .CYW(CYW)) i_cmp_scan_engine (.*);

  // memory model: answer at the falling edge; byte reads carry junk in the upper half
  always @(negedge clk) begin
    if (mem_req) begin
      mem_ack   = 1'b1;
      mem_rdata = mem_word ? {mem[6'(mem_addr + 1)], mem[6'(mem_addr)]}
                           : {8'hA5, mem[6'(mem_addr)]};
      mem_abort = (served == abort_idx);
      served++;
    end else begin
      mem_ack = 1'b0;
      mem_abort = 1'b0;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // independent reference: integer arithmetic over the bench memory
  task automatic model(input logic [61:0] v, output logic [7:0] p_o,
                       output logic [15:0] c_o, output logic [5:0] f_o);
    int p = int'(v[39:32]);
    int c = int'(v[31:16]);
    int w = v[59] ? 16 : 8;
    int mask = (1 << w) - 1;
    logic [5:0] f = FLAGS_PRE;
    for (int n = 0; n < 70000; n++) begin
      int m = v[59] ? (int'(mem[(p+1) & 63]) * 256 + int'(mem[p & 63])) : int'(mem[p & 63]);
      if (n != int'(v[15:8])) begin
        int av = int'(v[55:40]) & mask;
        int d = av - m;
        f[0] = d < 0;
        f[1] = 1'b1;
        f[3] = (av % 16) < (m % 16);
        f[4] = (d & mask) == 0;
        f[5] = ((d & mask) >> (w - 1)) & 1;
      end
      p = p + (v[61-1] ? -(w/8) : (w/8));
      c = (c - 1) & 16'hFFFF;
      f[2] = (c != 0);
      if (!v[61]) break;
      if (!(f[2] && !f[4])) break;
    end
    p_o = 8'(p); c_o = 16'(c); f_o = f;
  endtask

  task automatic run_vec(input logic [61:0] v, input bit disturb);
    logic [7:0] ep; logic [15:0] ec; logic [5:0] ef;
    int waited = 0;
    int n = int'(v[7:0]);
    @(negedge clk);
    repeat_mode = v[61]; step_down = v[60]; word_mode = v[59];
    opcode_lo = v[58:56]; acc_in = v[55:40]; ptr_in = AW'(v[39:32]);
    cnt_in = v[31:16]; flags_in = FLAGS_PRE;
    served = 0; abort_idx = int'(v[15:8]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin  // R12: start while busy
      start = 1'b1; opcode_lo = ~v[58:56]; ptr_in = 32'h20; cnt_in = 16'd2;
      acc_in = 16'h0021; repeat_mode = 1'b0;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    if (!done) begin
      chk("R11", "done never seen", 0, 1);
      return;
    end
    model(v, ep, ec, ef);
    chk("R2", "ptr_sel", 64'(ptr_sel), 64'(v[58:56]));
    chk(v[60] ? "R4" : "R3", "ptr_out", 64'(ptr_out), 64'(ep));
    chk("R6", "cnt_out", 64'(cnt_out), 64'(ec));
    chk(v[15:8] != 8'hFF ? "R10" : "R5", "flags_out", 64'(flags_out), 64'(ef));
    chk(v[61] ? "R9" : "R7", "cycles", 64'(cycles),
        64'(v[61] ? (10 + 14 * n) : 8));
    chk("R11", "end_found", 64'(end_found), 64'(ef[4]));
    chk("R11", "end_empty", 64'(end_empty), 64'(ec == 0));
    chk("R8", "elements read", 64'(served), 64'(n));
    @(negedge clk);
    chk("R11", "done after pulse", 64'(done), 64'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy",      64'(busy), 0);
    chk("R1", "done",      64'(done), 0);
    chk("R1", "mem_req",   64'(mem_req), 0);
    chk("R1", "ptr_out",   64'(ptr_out), 0);
    chk("R1", "cnt_out",   64'(cnt_out), 0);
    chk("R1", "flags_out", 64'(flags_out), 0);
    chk("R1", "cycles",    64'(cycles), 0);
    chk("R1", "reasons",   64'({end_found, end_empty, ptr_sel}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", 64'({busy, mem_req}), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

    // R12: second start while busy on a scan with no match
    run_vec(VEC[1], 1'b1);
    // R3: byte mode ignores upper read half (junk 0xA5) - single compare of equal byte
    run_vec({1'b0,1'b0,1'b0,3'd1,16'hFF09,8'h09,16'd2,8'hFF,8'd1}, 1'b0);
    chk("R3", "byte match despite upper bits", 64'(flags_out[4]), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule